// File: doc/BRIEF.md
# Bank Pin Interrupt Detector

This block watches the already-filtered input pins of one pin bank and raises a single interrupt request when a pin shows an event of the kind it is set up for. Out of reset every pin reports any change of level. A per-pin switch selects an extended mode instead. In that mode each pin can detect one edge direction (rising or falling) or one level (high or low). Events are collected in a status register that software reads to see and acknowledge them. A per-pin mask decides which collected events drive the request line.

Every setting is held in a set/clear register pair. Writing a one to a bit of the "on" address sets that bit and writing a one to the "off" address clears it, so software never has to read, modify and write back. The request line is the OR of all status bits that are unmasked. Events on masked pins are still collected, so unmasking a pin with a stored event raises the request at once. Banks that share one request line are handled outside this block.

Top module: `gpio_irq_bank`

## Requirements
- R1: Writing a one to bit n at word address 0 unmasks pin n. Writing a one at address 1 masks it. Address 2 reads the mask, where 1 means unmasked. Zero bits in a write leave the mask unchanged.
- R2: A read of address 3 returns the event status and clears every bit that has no new event in that cycle. With no such read, a status bit never falls.
- R3: `irq_o` is high exactly when some status bit is set for an unmasked pin. Events on masked pins are still recorded in the status.
- R4: With the extended mode off for a pin, the pin records an event on each rising and each falling change. A change is judged against the pin's value on the previous clock.
- R5: Writing ones at address 4 turns the extended mode on for those pins. Writing ones at address 5 turns it off. Address 6 reads the setting, where 1 means extended.
- R6: Writing ones at address 8 selects level detection and writing ones at address 7 selects edge detection. Address 9 reads the choice, where 1 means level.
- R7: Writing ones at address 10 selects rising/high polarity and writing ones at address 11 selects falling/low polarity. Address 12 reads the choice, where 1 means rising or high. In extended edge mode only the selected direction records an event.
- R8: In extended level mode the status bit is set on every clock while the pin is at its active level. A clearing read is therefore followed by the bit reappearing.
- R9: An event that occurs in the same cycle as a status read is not lost. That read does not return it, and the next read does.
- R10: After reset the mask, mode, kind, polarity and status all read 0 and `irq_o` is low. Pins held at any value during reset record no event when reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | NPINS | Filtered pin levels |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of address 3 clears the status |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | NPINS | Write data, one bit per pin |
| reg_rdata | output | NPINS | Read data for the addressed register, valid in the cycle of `reg_rd` |
| irq_o | output | 1 | Bank interrupt request |

## Verification
The bench targets several corner cases, and each one has a known wrong outcome:
- **Level mode after a clearing read.** A pin at its active level must show up again right after the read. A design that treated levels like edges would report nothing the second time.
- **Event in the read cycle.** A pin that toggles in the same cycle as a status read must appear on the next read. A design that cleared the whole status would lose it.
- **Masked event, then unmask.** An event on a masked pin must leave `irq_o` low, and unmasking the pin must raise `irq_o` with no new event. A design that dropped masked events would stay quiet.
- **Mixed modes in one vector.** One vector mixes any-edge, single-edge and level pins with both polarities. A swapped polarity or kind decode would flip specific status bits.

// File: rtl/gpio_irq_pkg.sv
// Shared definitions for the bank pin interrupt detector: register
// addresses and the slot numbering of the set/clear configuration words.
package gpio_irq_pkg;

    localparam int ADDR_W = 4;
    localparam int NCFG   = 4;

    // slot numbers of the configuration words
    localparam int CFG_MASK  = 0;
    localparam int CFG_XMODE = 1;
    localparam int CFG_KIND  = 2;
    localparam int CFG_POL   = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_MASK_ON   = 4'd0,
        A_MASK_OFF  = 4'd1,
        A_MASK      = 4'd2,
        A_STATUS    = 4'd3,
        A_XM_ON     = 4'd4,
        A_XM_OFF    = 4'd5,
        A_XM        = 4'd6,
        A_SEL_EDGE  = 4'd7,
        A_SEL_LEVEL = 4'd8,
        A_KIND      = 4'd9,
        A_SEL_HI    = 4'd10,
        A_SEL_LO    = 4'd11,
        A_POL       = 4'd12
    } reg_addr_e;

    // address whose write-one bits set the given configuration word
    function automatic logic [ADDR_W-1:0] cfg_set_addr(input int idx);
        case (idx)
            CFG_MASK:  return A_MASK_ON;
            CFG_XMODE: return A_XM_ON;
            CFG_KIND:  return A_SEL_LEVEL;
            default:   return A_SEL_HI;
        endcase
    endfunction

    // address whose write-one bits clear the given configuration word
    function automatic logic [ADDR_W-1:0] cfg_clr_addr(input int idx);
        case (idx)
            CFG_MASK:  return A_MASK_OFF;
            CFG_XMODE: return A_XM_OFF;
            CFG_KIND:  return A_SEL_EDGE;
            default:   return A_SEL_LO;
        endcase
    endfunction

endpackage

// File: rtl/gpio_irq_setclr.sv
// One configuration word written through a set/clear pair.
// Assumes at most one of set_i / clr_i is high per cycle (one address).
module gpio_irq_setclr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_i,
    input  logic         clr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] q_o
);

    // apply write-one-to-set or write-one-to-clear, reset to all zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= '0;
        else if (set_i)
            q_o <= q_o | wdata_i;
        else if (clr_i)
            q_o <= q_o & ~wdata_i;
    end

endmodule

// File: rtl/gpio_irq_detect.sv
// Per-pin event detection. Compares each pin with its value one clock
// earlier (edge) or with its active level (level), per the mode words.
// Assumes pin_i is already synchronous to clk. The history register
// follows the pins during reset too, so releasing reset makes no edge.
module gpio_irq_detect #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic [NPINS-1:0] pin_i,
    input  logic [NPINS-1:0] xmode_i,
    input  logic [NPINS-1:0] kind_i,
    input  logic [NPINS-1:0] pol_i,
    output logic [NPINS-1:0] evt_o
);

    logic [NPINS-1:0] prev_q;

    // keep the pin values of the previous clock, in and out of reset
    always_ff @(posedge clk) begin
        prev_q <= pin_i;
    end

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        logic rise, fall;
        assign rise = pin_i[g] & ~prev_q[g];
        assign fall = ~pin_i[g] & prev_q[g];

        // choose the event kind for this pin
        always_comb begin
            if (!xmode_i[g])
                evt_o[g] = rise | fall;
            else if (!kind_i[g])
                evt_o[g] = pol_i[g] ? rise : fall;
            else
                evt_o[g] = pol_i[g] ? pin_i[g] : ~pin_i[g];
        end
    end

endmodule

// File: rtl/gpio_irq_status.sv
// Event status collector: sticky bits, cleared as a whole by a status
// read, with events of the read cycle merged in after the clear.
module gpio_irq_status #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] evt_i,
    input  logic             clr_i,
    output logic [NPINS-1:0] status_o
);

    // accumulate events; a read drops old bits but keeps new ones
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_o <= '0;
        else
            status_o <= (clr_i ? '0 : status_o) | evt_i;
    end

endmodule

// File: rtl/gpio_irq_bank.sv
// Bank pin interrupt detector top. Register port with combinational read
// data, four set/clear configuration words, per-pin detection, a
// clear-on-read status and one request line. Assumes filtered pins.
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pin_i,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [NPINS-1:0]  reg_wdata,
    output logic [NPINS-1:0]  reg_rdata,
    output logic              irq_o
);

    logic [NCFG-1:0][NPINS-1:0] cfg_q;
    logic [NPINS-1:0] mask_w, xmode_w, kind_w, pol_w;
    logic [NPINS-1:0] evt_w, status_w;
    logic             stat_rd;
    reg_addr_e        addr_e;

    assign addr_e  = reg_addr_e'(reg_addr);
    assign stat_rd = reg_rd && (addr_e == A_STATUS);

    for (genvar c = 0; c < NCFG; c++) begin : g_cfg
        logic set_hit, clr_hit;
        assign set_hit = reg_wr && (reg_addr == cfg_set_addr(c));
        assign clr_hit = reg_wr && (reg_addr == cfg_clr_addr(c));
        gpio_irq_setclr #(.W(NPINS)) u_word (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_i   (set_hit),
            .clr_i   (clr_hit),
            .wdata_i (reg_wdata),
            .q_o     (cfg_q[c])
        );
    end

    assign mask_w  = cfg_q[CFG_MASK];
    assign xmode_w = cfg_q[CFG_XMODE];
    assign kind_w  = cfg_q[CFG_KIND];
    assign pol_w   = cfg_q[CFG_POL];

    gpio_irq_detect #(.NPINS(NPINS)) u_det (
        .clk     (clk),
        .pin_i   (pin_i),
        .xmode_i (xmode_w),
        .kind_i  (kind_w),
        .pol_i   (pol_w),
        .evt_o   (evt_w)
    );

    gpio_irq_status #(.NPINS(NPINS)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_w),
        .clr_i    (stat_rd),
        .status_o (status_w)
    );

    // request when any unmasked pin holds an event
    assign irq_o = |(status_w & mask_w);

    // read multiplexer, zero when idle or unmapped
    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (addr_e)
                A_MASK:   reg_rdata = mask_w;
                A_STATUS: reg_rdata = status_w;
                A_XM:     reg_rdata = xmode_w;
                A_KIND:   reg_rdata = kind_w;
                A_POL:    reg_rdata = pol_w;
                default:  reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_irq_bank_chk.sv
// Property checker for gpio_irq_bank, attached with bind below.
module gpio_irq_bank_chk
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pin0,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [NPINS-1:0]  reg_wdata,
    input logic              irq_o,
    input logic [NPINS-1:0]  mask,
    input logic              xm0,
    input logic              kind0,
    input logic              pol0,
    input logic [NPINS-1:0]  status,
    input logic [NPINS-1:0]  evt
);

    AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_MASK_ON) |=> ((mask & $past(reg_wdata)) == $past(reg_wdata))); // R1
    AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_MASK_OFF) |=> ((mask & $past(reg_wdata)) == '0)); // R1
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_STATUS) |=> ((status & ~$past(evt)) == '0)); // R2
    AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_addr == A_STATUS) |=> (($past(status) & ~status) == '0)); // R2
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq_o); // R3
    AST_ANY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!xm0 && (pin0 != $past(pin0))) |=> status[0]); // R4
    AST_LEVEL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (xm0 && kind0 && pol0 && pin0) |=> status[0]); // R8
    AST_EVT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(evt) & ~status) == '0)); // R9

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin0      (pin_i[0]),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq_o     (irq_o),
    .mask      (mask_w),
    .xm0       (xmode_w[0]),
    .kind0     (kind_w[0]),
    .pol0      (pol_w[0]),
    .status    (status_w),
    .evt       (evt_w)
);

// File: tb/sim_gpio_irq_bank.sv
module sim_gpio_irq_bank;

    localparam int N = 32;
    localparam logic [3:0] AD_MON = 4'd0, AD_MOFF = 4'd1, AD_MASK = 4'd2, AD_STAT = 4'd3,
                           AD_XON = 4'd4, AD_XOFF = 4'd5, AD_XM = 4'd6,
                           AD_EDGE = 4'd7, AD_LEVEL = 4'd8, AD_KIND = 4'd9,
                           AD_HI = 4'd10, AD_LO = 4'd11, AD_POL = 4'd12;

    typedef struct packed {
        logic [N-1:0] xm;
        logic [N-1:0] kd;
        logic [N-1:0] pl;
        logic [N-1:0] bef;
        logic [N-1:0] aft;
        logic [N-1:0] exp;
    } vec_t;

    // xmode, kind(1=level), pol(1=rise/high), pins before, pins after, expected status
    localparam vec_t VEC [7] = '{
        '{32'h0, 32'h0, 32'h0, 32'h0000_0000, 32'h0000_00FF, 32'h0000_00FF},
        '{32'h0, 32'h0, 32'h0, 32'hFFFF_0000, 32'h0F0F_0F0F, 32'hF0F0_0F0F},
        '{32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF, 32'h00FF_00FF, 32'h0F0F_0F0F, 32'h0F00_0F00},
        '{32'hFFFF_FFFF, 32'h0, 32'h0, 32'h00FF_00FF, 32'h0F0F_0F0F, 32'h00F0_00F0},
        '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_1234, 32'h0000_1234},
        '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_0FF0, 32'h0000_F00F},
        '{32'h0000_FFFF, 32'h0000_00FF, 32'h0000_F0F0, 32'h0000_0F0F, 32'h00F0_F03C, 32'h00F0_FF33}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pin_i = '0;
    logic         reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]   reg_addr = '0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] reg_rdata;
    logic         irq_o;

    int  n_chk = 0, n_bad = 0;
    bit  done = 0;
    logic [N-1:0] d;

    always #2 clk = ~clk;

    gpio_irq_bank #(.NPINS(N)) u0 (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [N-1:0] v);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [N-1:0] v);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic pins(input logic [N-1:0] v);
        @(negedge clk); pin_i = v;
    endtask

    task automatic setword(input logic [3:0] on, input logic [3:0] off, input logic [N-1:0] v);
        wr(on, v);
        wr(off, ~v);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R10 reset state
        do_reset();
        rd(AD_MASK, d); check("R10 mask", d, '0);
        rd(AD_STAT, d); check("R10 status", d, '0);
        rd(AD_XM,   d); check("R10 xmode", d, '0);
        rd(AD_KIND, d); check("R10 kind", d, '0);
        rd(AD_POL,  d); check("R10 pol", d, '0);
        check("R10 irq", {31'b0, irq_o}, '0);

        // vector table: R4 any-edge, R7 single edge, R8 levels, mixed
        for (int i = 0; i < 7; i++) begin
            setword(AD_XON, AD_XOFF, VEC[i].xm);
            setword(AD_LEVEL, AD_EDGE, VEC[i].kd);
            setword(AD_HI, AD_LO, VEC[i].pl);
            pins(VEC[i].bef);
            rd(AD_STAT, d);
            pins(VEC[i].aft);
            rd(AD_STAT, d);
            check($sformatf("R4/R7/R8 vector %0d", i), d, VEC[i].exp);
        end

        // R10 pins held nonzero through reset: no event on release
        pin_i = 32'hA5A5_A5A5;
        do_reset();
        rd(AD_STAT, d); check("R10 no event after reset", d, '0);

        // R1 mask set/clear readback
        wr(AD_MON, 32'h0000_00F0);
        wr(AD_MON, 32'h0000_0003);
        rd(AD_MASK, d); check("R1 mask set", d, 32'h0000_00F3);
        wr(AD_MOFF, 32'h0000_0030);
        rd(AD_MASK, d); check("R1 mask clear", d, 32'h0000_00C3);

        // R3 masked event recorded, no request; unmask raises request
        pins(pin_i ^ 32'h0000_0100);
        @(negedge clk); check("R3 masked quiet", {31'b0, irq_o}, '0);
        rd(AD_STAT, d); check("R3 masked recorded", d, 32'h0000_0100);
        pins(pin_i ^ 32'h0000_0200);
        @(negedge clk); check("R3 masked quiet 2", {31'b0, irq_o}, '0);
        wr(AD_MON, 32'h0000_0200);
        check("R3 unmask raises irq", {31'b0, irq_o}, 32'h1);
        // R2 read clears, second read is empty
        rd(AD_STAT, d); check("R2 first read", d, 32'h0000_0200);
        check("R2 irq drops after read", {31'b0, irq_o}, '0);
        rd(AD_STAT, d); check("R2 second read empty", d, '0);

        // R8 level high reappears after clearing read
        setword(AD_XON, AD_XOFF, 32'h0000_0010);
        setword(AD_LEVEL, AD_EDGE, 32'h0000_0010);
        setword(AD_HI, AD_LO, 32'h0000_0010);
        pins(pin_i & ~32'h0000_0010);
        rd(AD_STAT, d);
        pins(pin_i | 32'h0000_0010);
        rd(AD_STAT, d); check("R8 level seen", d, 32'h0000_0010);
        rd(AD_STAT, d); check("R8 level reappears", d, 32'h0000_0010);
        pins(pin_i & ~32'h0000_0010);
        rd(AD_STAT, d); check("R8 last set before drop", d, 32'h0000_0010);
        rd(AD_STAT, d); check("R8 inactive level clear", d, '0);

        // R9 event in the read cycle is kept
        @(negedge clk); reg_rd = 1'b1; reg_addr = AD_STAT; pin_i = pin_i ^ 32'h0010_0000;
        #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
        check("R9 read cycle does not show", d, '0);
        rd(AD_STAT, d); check("R9 kept for next read", d, 32'h0010_0000);

        // R5 R6 R7 readback from fresh reset
        do_reset();
        wr(AD_XON, 32'h0000_00FF); wr(AD_XOFF, 32'h0000_000F);
        rd(AD_XM, d); check("R5 xmode readback", d, 32'h0000_00F0);
        wr(AD_LEVEL, 32'h0000_000F); wr(AD_EDGE, 32'h0000_0003);
        rd(AD_KIND, d); check("R6 kind readback", d, 32'h0000_000C);
        wr(AD_HI, 32'h0000_00F0); wr(AD_LO, 32'h0000_0030);
        rd(AD_POL, d); check("R7 pol readback", d, 32'h0000_00C0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule